// File: doc/BRIEF.md
# Single-Step Operand Shifter with Carry-Out

This block shifts or rotates a data word by any permitted amount in one step, ahead of an ALU's second operand. A small code on the kind input picks one of five operations: logical left, logical right, arithmetic right, rotate right, and a one-place rotate through the carry flag. The amount is taken from a short immediate field or from the low byte of a register operand, as chosen by a select input. Alongside the word the block produces a shifter carry-out, which the flag logic can use.

A request is presented with `in_valid` for one cycle. The shifted word and its carry are captured in output registers and appear on the next clock edge together with `out_valid`. A new request may be issued every cycle. When no request is presented, the outputs keep their last values.

Top module: `barrel_shift_unit`

## Requirements
- R1: After reset `out_valid`, `out_data` and `out_carry` are 0. Each cycle with `in_valid` high gives exactly one result on the next cycle, with `out_valid` high. A cycle with `in_valid` low gives `out_valid` low on the next cycle.
- R2: Kind code 0 is a logical left shift. Vacated low bits become 0. The carry-out is the last bit moved out of bit 31, so a left shift by 32 gives carry = data bit 0. The immediate amount 0..31 is used as it stands.
- R3: Kind code 1 is a logical right shift. Vacated high bits become 0. The carry-out is data bit n-1.
- R4: Kind code 2 is an arithmetic right shift. Vacated high bits are copies of data bit 31. The carry-out is data bit n-1.
- R5: Kind code 3 is a rotate right by n. Bits that leave bit 0 come back in at bit 31. The carry-out equals result bit 31.
- R6: Kind code 4 always rotates by exactly one place through the carry. The incoming carry enters bit 31, and old bit 0 becomes the carry-out. The amount inputs are ignored.
- R7: A register-sourced amount of 0 with kind codes 0..3 passes the data through unchanged, and the carry-out equals the incoming carry.
- R8: When `in_amt_sel` is 1 the amount is bits [7:0] of `in_reg_amt`, and higher register bits have no effect. When it is 0 the amount is `in_imm`, and `in_reg_amt` has no effect.
- R9: Register-sourced amounts above 32 behave as follows. Logical shifts give 0 with carry 0. Arithmetic right gives 32 copies of bit 31, with carry = bit 31. Rotate uses the amount modulo 32, and a nonzero multiple of 32 leaves the data unchanged with carry = bit 31. Logical shifts by exactly 32 follow R2/R3.
- R10: For kind codes 1, 2 and 3, an immediate of 0 encodes an amount of 32.
- R11: Kind codes 5, 6 and 7 pass the data through unchanged, and the carry-out equals the incoming carry.
- R12: While `in_valid` is low, `out_data` and `out_carry` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| in_data | input | 32 | Word to shift |
| in_kind | input | 3 | Operation code (0 LSL, 1 LSR, 2 ASR, 3 ROR, 4 RRX) |
| in_amt_sel | input | 1 | Amount source: 0 immediate, 1 register |
| in_imm | input | 5 | Immediate amount |
| in_reg_amt | input | 32 | Register operand holding the amount in bits [7:0] |
| in_carry | input | 1 | Current carry flag |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_data | output | 32 | Shifted word |
| out_carry | output | 1 | Shifter carry-out |

## Verification
Directed vectors cover each kind at its edge amounts: 0, 1, 31, 32, 33 and values well above 32. These show whether the amount clamp and the immediate-zero encoding were applied per kind. Words with bit 31 set and clear separate the arithmetic fill from the logical fill. Words with distinct patterns at bit 0 and bit 31 show whether the carry was taken from the correct end. Register operands with their upper bits set, and immediates that disagree with the register amount, show which source was used. A left shift by three feeds a bench-side add, which checks x + (x << 3) = 9·x. A long stream of back-to-back random requests checks ordering and one-cycle latency.

// File: rtl/bsh_pkg.sv
package bsh_pkg;
   localparam logic [2:0] KIND_LSL = 3'd0;
   localparam logic [2:0] KIND_LSR = 3'd1;
   localparam logic [2:0] KIND_ASR = 3'd2;
   localparam logic [2:0] KIND_ROR = 3'd3;
   localparam logic [2:0] KIND_RRX = 3'd4;

   localparam int unsigned FUNNEL_OPERATOR = 0;
   localparam int unsigned FUNNEL_STAGED   = 1;
endpackage

// File: rtl/bsh_amount_sel.sv
module bsh_amount_sel #(
   parameter int unsigned WIDTH = 32,
   parameter int unsigned IMM_W = 5,
   parameter int unsigned REG_W = 8,
   parameter int unsigned N_W   = 6
) (
   input  logic [2:0]       kind,
   input  logic             use_reg,
   input  logic [IMM_W-1:0] imm,
   input  logic [REG_W-1:0] reg_amt,
   output logic [N_W-1:0]   amount
);
   import bsh_pkg::*;

   localparam int unsigned LIM_LOGIC = WIDTH + 1;
   localparam int unsigned LIM_ARITH = WIDTH;

   logic [N_W-1:0]   imm_plain;
   logic [N_W-1:0]   imm_full;
   logic [N_W-1:0]   reg_logic;
   logic [N_W-1:0]   reg_arith;
   logic [N_W-1:0]   reg_rot;
   logic [IMM_W-1:0] reg_low;

   assign reg_low   = reg_amt[IMM_W-1:0];
   assign imm_plain = N_W'(imm);
   assign imm_full  = (imm == '0) ? N_W'(WIDTH) : imm_plain;
   assign reg_logic = (reg_amt > REG_W'(LIM_LOGIC)) ? N_W'(LIM_LOGIC) : N_W'(reg_amt);
   assign reg_arith = (reg_amt > REG_W'(LIM_ARITH)) ? N_W'(LIM_ARITH) : N_W'(reg_amt);
   assign reg_rot   = (reg_amt == '0) ? '0 :
                      (reg_low == '0) ? N_W'(WIDTH) : N_W'(reg_low);

   always_comb begin
      amount = '0;
      case (kind)
         KIND_LSL: amount = use_reg ? reg_logic : imm_plain;
         KIND_LSR: amount = use_reg ? reg_logic : imm_full;
         KIND_ASR: amount = use_reg ? reg_arith : imm_full;
         KIND_ROR: amount = use_reg ? reg_rot   : imm_full;
         KIND_RRX: amount = N_W'(1);
         default:  amount = '0;
      endcase
   end
endmodule

// File: rtl/bsh_funnel.sv
module bsh_funnel #(
   parameter int unsigned EXT_W = 65,
   parameter int unsigned N_W   = 6,
   parameter int unsigned STYLE = 1
) (
   input  logic [EXT_W-1:0] din,
   input  logic [N_W-1:0]   n,
   output logic [EXT_W-1:0] dout
);
   import bsh_pkg::*;

   if (STYLE == FUNNEL_OPERATOR) begin : g_operator
      assign dout = din >> n;
   end else begin : g_staged
      logic [EXT_W-1:0] stage [N_W+1];
      assign stage[0] = din;
      for (genvar k = 0; k < N_W; k++) begin : g_level
         assign stage[k+1] = n[k] ? (stage[k] >> (2 ** k)) : stage[k];
      end
      assign dout = stage[N_W];
   end
endmodule

// File: rtl/bsh_core.sv
module bsh_core #(
   parameter int unsigned WIDTH = 32,
   parameter int unsigned N_W   = 6,
   parameter int unsigned STYLE = 1
) (
   input  logic [WIDTH-1:0] data,
   input  logic             cin,
   input  logic [2:0]       kind,
   input  logic [N_W-1:0]   amount,
   output logic [WIDTH-1:0] result,
   output logic             cout
);
   import bsh_pkg::*;

   localparam int unsigned EXT_W = 2 * WIDTH + 1;

   logic             go_left;
   logic [WIDTH-1:0] fill;
   logic [WIDTH:0]   left_in;
   logic [WIDTH:0]   left_rev;
   logic [EXT_W-1:0] ext;
   logic [EXT_W-1:0] shifted;
   logic [WIDTH:0]   low;
   logic [WIDTH:0]   low_rev;

   always_comb begin
      go_left = 1'b0;
      fill    = '0;
      case (kind)
         KIND_LSL: go_left = 1'b1;
         KIND_ASR: fill = {WIDTH{data[WIDTH-1]}};
         KIND_ROR: fill = data;
         KIND_RRX: fill = {{(WIDTH-1){1'b0}}, cin};
         default:  fill = '0;
      endcase
   end

   assign left_in = {cin, data};

   always_comb begin
      for (int i = 0; i <= WIDTH; i++) left_rev[i] = left_in[WIDTH-i];
   end

   assign ext = go_left ? {{WIDTH{1'b0}}, left_rev} : {fill, data, cin};

   bsh_funnel #(
      .EXT_W (EXT_W),
      .N_W   (N_W),
      .STYLE (STYLE)
   ) u_funnel (
      .din  (ext),
      .n    (amount),
      .dout (shifted)
   );

   assign low = shifted[WIDTH:0];

   always_comb begin
      for (int i = 0; i <= WIDTH; i++) low_rev[i] = low[WIDTH-i];
   end

   assign result = go_left ? low_rev[WIDTH-1:0] : low[WIDTH:1];
   assign cout   = go_left ? low_rev[WIDTH]     : low[0];
endmodule

// File: rtl/barrel_shift_unit.sv
module barrel_shift_unit #(
   parameter int unsigned WIDTH = 32,
   parameter int unsigned REG_W = 8,
   parameter int unsigned STYLE = 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   input  logic [WIDTH-1:0]          in_data,
   input  logic [2:0]                in_kind,
   input  logic                      in_amt_sel,
   input  logic [$clog2(WIDTH)-1:0]  in_imm,
   input  logic [WIDTH-1:0]          in_reg_amt,
   input  logic                      in_carry,
   output logic                      out_valid,
   output logic [WIDTH-1:0]          out_data,
   output logic                      out_carry
);
   import bsh_pkg::*;

   localparam int unsigned IMM_W = $clog2(WIDTH);
   localparam int unsigned N_W   = IMM_W + 1;

   if (WIDTH < 4 || (WIDTH & (WIDTH - 1)) != 0) begin : g_bad_width
      $error("barrel_shift_unit: WIDTH must be a power of two, at least 4");
   end
   if (REG_W < N_W || REG_W > WIDTH) begin : g_bad_reg_w
      $error("barrel_shift_unit: REG_W must lie between log2(WIDTH)+1 and WIDTH");
   end
   if (STYLE != FUNNEL_OPERATOR && STYLE != FUNNEL_STAGED) begin : g_bad_style
      $error("barrel_shift_unit: STYLE selects an unknown funnel variant");
   end

   logic [N_W-1:0]   amount;
   logic [WIDTH-1:0] comb_result;
   logic             comb_carry;

   bsh_amount_sel #(
      .WIDTH (WIDTH),
      .IMM_W (IMM_W),
      .REG_W (REG_W),
      .N_W   (N_W)
   ) u_amount (
      .kind    (in_kind),
      .use_reg (in_amt_sel),
      .imm     (in_imm),
      .reg_amt (in_reg_amt[REG_W-1:0]),
      .amount  (amount)
   );

   bsh_core #(
      .WIDTH (WIDTH),
      .N_W   (N_W),
      .STYLE (STYLE)
   ) u_core (
      .data   (in_data),
      .cin    (in_carry),
      .kind   (in_kind),
      .amount (amount),
      .result (comb_result),
      .cout   (comb_carry)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_carry <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_data  <= comb_result;
            out_carry <= comb_carry;
         end
      end
   end

   p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_data) && $stable(out_carry)));
   p_lsl_zero_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_kind == KIND_LSL && !in_amt_sel && in_imm != '0) |=> !out_data[0]);
   p_asr_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_kind == KIND_ASR) |=> (out_data[WIDTH-1] == $past(in_data[WIDTH-1])));
   p_rrx_through_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_kind == KIND_RRX) |=>
      (out_carry == $past(in_data[0]) && out_data[WIDTH-1] == $past(in_carry)));
   p_zero_amount_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_amt_sel && in_reg_amt[REG_W-1:0] == '0 && in_kind != KIND_RRX) |=>
      (out_data == $past(in_data) && out_carry == $past(in_carry)));
   p_lsr_overrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_amt_sel && in_kind == KIND_LSR && in_reg_amt[REG_W-1:0] > REG_W'(WIDTH)) |=>
      (out_data == '0 && !out_carry));
endmodule

// File: tb/barrel_shift_unit_bench.sv
`timescale 1ns/1ps
module barrel_shift_unit_bench;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         in_valid;
   logic [W-1:0] in_data;
   logic [2:0]   in_kind;
   logic         in_amt_sel;
   logic [4:0]   in_imm;
   logic [W-1:0] in_reg_amt;
   logic         in_carry;
   logic         out_valid;
   logic [W-1:0] out_data;
   logic         out_carry;

   always #10 clk = ~clk;

   barrel_shift_unit u_barrel_shift_unit (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_data    (in_data),
      .in_kind    (in_kind),
      .in_amt_sel (in_amt_sel),
      .in_imm     (in_imm),
      .in_reg_amt (in_reg_amt),
      .in_carry   (in_carry),
      .out_valid  (out_valid),
      .out_data   (out_data),
      .out_carry  (out_carry)
   );

   typedef struct {
      logic [W:0] val;
      string      tag;
   } item_t;

   item_t q[$];
   int    total = 0;
   int    bad   = 0;

   task automatic chk(input bit ok, input string tag, input logic [W:0] act, input logic [W:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // returns {carry, word}
   function automatic logic [W:0] model(input logic [2:0] k, input logic sel, input logic [4:0] imm,
                                        input logic [W-1:0] rv, input logic [W-1:0] d, input logic cin);
      logic [W-1:0] r;
      logic         c;
      int           n;
      int           m;
      r = d;
      c = cin;
      if (k == 3'd4) return {d[0], cin, d[W-1:1]};
      if (k > 3'd4) return {cin, d};
      if (sel) n = int'(rv[7:0]);
      else if (k == 3'd0) n = int'(imm);
      else n = (imm == 5'd0) ? 32 : int'(imm);
      if (n == 0) return {cin, d};
      case (k)
         3'd0: begin
            for (int i = 0; i < W; i++) r[i] = (i - n >= 0) ? d[i-n] : 1'b0;
            c = (n <= 32) ? d[32-n] : 1'b0;
         end
         3'd1: begin
            for (int i = 0; i < W; i++) r[i] = (i + n < W) ? d[i+n] : 1'b0;
            c = (n <= 32) ? d[n-1] : 1'b0;
         end
         3'd2: begin
            for (int i = 0; i < W; i++) r[i] = (i + n < W) ? d[i+n] : d[W-1];
            c = (n <= 32) ? d[n-1] : d[W-1];
         end
         default: begin
            m = n % 32;
            for (int i = 0; i < W; i++) r[i] = d[(i+m)%W];
            c = r[W-1];
         end
      endcase
      return {c, r};
   endfunction

   task automatic send(input logic [2:0] k, input logic sel, input logic [4:0] imm,
                       input logic [W-1:0] rv, input logic [W-1:0] d, input logic cin, input string tag);
      item_t it;
      @(negedge clk);
      in_valid   = 1'b1;
      in_kind    = k;
      in_amt_sel = sel;
      in_imm     = imm;
      in_reg_amt = rv;
      in_data    = d;
      in_carry   = cin;
      it.val = model(k, sel, imm, rv, d, cin);
      it.tag = tag;
      q.push_back(it);
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (q.size() == 0) begin
            chk(1'b0, "R1 unexpected result", {out_carry, out_data}, '0);
         end else begin
            item_t it;
            it = q.pop_front();
            chk({out_carry, out_data} === it.val, it.tag, {out_carry, out_data}, it.val);
         end
      end
   end

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(1'b0, "watchdog expired", '0, '0);
      finish_run();
   end

   initial begin
      logic [W-1:0] x;
      logic [W:0]   held;
      rst_n = 1'b0;
      in_valid = 1'b0; in_data = '0; in_kind = '0; in_amt_sel = 1'b0;
      in_imm = '0; in_reg_amt = '0; in_carry = 1'b0;
      repeat (3) @(negedge clk);
      chk(out_valid === 1'b0 && out_data === '0 && out_carry === 1'b0, "R1 reset state",
          {out_carry, out_data}, '0);
      rst_n = 1'b1;

      // R2 logical left
      send(3'd0, 1'b0, 5'd0,  '0, 32'h8000_0001, 1'b1, "R2 lsl imm0");
      send(3'd0, 1'b0, 5'd1,  '0, 32'h8000_0001, 1'b0, "R2 lsl 1");
      send(3'd0, 1'b0, 5'd31, '0, 32'h0000_0003, 1'b0, "R2 lsl 31");
      send(3'd0, 1'b1, 5'd0,  32'd32, 32'h0000_0001, 1'b0, "R2 lsl reg 32");
      send(3'd0, 1'b1, 5'd0,  32'd33, 32'hFFFF_FFFF, 1'b1, "R9 lsl reg 33");
      // R3 logical right
      send(3'd1, 1'b0, 5'd1,  '0, 32'h8000_0001, 1'b0, "R3 lsr 1");
      send(3'd1, 1'b0, 5'd0,  '0, 32'h8000_0000, 1'b0, "R10 lsr imm0 is 32");
      send(3'd1, 1'b1, 5'd0,  32'd32, 32'h7FFF_FFFF, 1'b1, "R3 lsr reg 32");
      send(3'd1, 1'b1, 5'd0,  32'd100, 32'hFFFF_FFFF, 1'b1, "R9 lsr reg 100");
      // R4 arithmetic right
      send(3'd2, 1'b0, 5'd4,  '0, 32'h8000_00F8, 1'b0, "R4 asr neg 4");
      send(3'd2, 1'b0, 5'd4,  '0, 32'h7000_0008, 1'b1, "R4 asr pos 4");
      send(3'd2, 1'b0, 5'd0,  '0, 32'h8000_0000, 1'b0, "R10 asr imm0 is 32");
      send(3'd2, 1'b1, 5'd0,  32'd200, 32'h8123_4567, 1'b0, "R9 asr reg 200");
      send(3'd2, 1'b1, 5'd0,  32'd200, 32'h0123_4567, 1'b1, "R9 asr reg 200 pos");
      // R5 rotate right
      send(3'd3, 1'b0, 5'd8,  '0, 32'h1234_5680, 1'b0, "R5 ror 8");
      send(3'd3, 1'b0, 5'd0,  '0, 32'h8765_4321, 1'b0, "R10 ror imm0 is 32");
      send(3'd3, 1'b1, 5'd0,  32'd40, 32'h1234_5678, 1'b0, "R9 ror reg 40");
      send(3'd3, 1'b1, 5'd0,  32'd64, 32'h0000_0001, 1'b1, "R9 ror reg 64");
      // R6 rotate through carry
      send(3'd4, 1'b0, 5'd9,  32'd7, 32'h0000_0003, 1'b1, "R6 rrx cin1");
      send(3'd4, 1'b1, 5'd0,  32'd0, 32'h8000_0002, 1'b0, "R6 rrx cin0");
      // R7 zero register amount
      for (int k = 0; k < 4; k++)
         send(3'(k), 1'b1, 5'd7, 32'hFFFF_FF00, 32'hA5A5_5A5A, 1'(k), "R7 reg amount zero");
      // R8 source selection
      send(3'd1, 1'b1, 5'd1,  32'hFFFF_FF04, 32'hF000_000F, 1'b0, "R8 reg low byte only");
      send(3'd1, 1'b0, 5'd4,  32'h0000_0011, 32'hF000_000F, 1'b0, "R8 imm ignores reg");
      // R11 unused codes
      for (int k = 5; k < 8; k++)
         send(3'(k), 1'b1, 5'd3, 32'd5, 32'hDEAD_BEEF, 1'(k & 1), "R11 unused code");
      idle();

      // R12 hold while idle
      @(negedge clk);
      held = {out_carry, out_data};
      in_data = ~in_data; in_kind = 3'd0; in_imm = 5'd5; in_carry = ~in_carry;
      repeat (3) @(negedge clk);
      chk(out_valid === 1'b0 && {out_carry, out_data} === held, "R12 hold while idle",
          {out_carry, out_data}, held);

      // R2 feeding an add: x + (x << 3) == 9x
      for (int j = 0; j < 4; j++) begin
         x = (j == 0) ? 32'd7 : (j == 1) ? 32'd12345 : $urandom;
         send(3'd0, 1'b0, 5'd3, '0, x, 1'b0, "R2 lsl 3 for add");
         idle();
         chk(x + out_data === 32'(9 * x), "R2 x plus x<<3 is 9x", {1'b0, x + out_data}, {1'b0, 32'(9 * x)});
      end

      // back-to-back random stream (R1 ordering)
      for (int j = 0; j < 400; j++)
         send(3'($urandom_range(0, 7)), 1'($urandom), 5'($urandom), $urandom_range(0, 1) ? 32'($urandom_range(0, 70)) : $urandom,
              $urandom, 1'($urandom), "R1 random stream");
      idle();
      repeat (3) @(negedge clk);
      chk(q.size() == 0, "R1 every request answered", (W+1)'(q.size()), '0);
      finish_run();
   end
endmodule